// File: doc/BRIEF.md
# Half-to-single precision widening converter

This block turns a 16-bit half-precision floating-point value into the 32-bit single-precision value that represents it exactly. Every finite half value fits in single precision, so no rounding is needed. The work is sorting the input into a class, normalizing subnormals, and deciding what special values become. The result and an invalid-operation flag are registered on an input strobe and appear one clock later.

Two control inputs shape each conversion. `alt_fmt` selects a half format with no infinity or NaN encodings. In that format the all-ones exponent is an ordinary exponent, which extends the finite range by one binade. `dnan_en` makes every NaN input produce one fixed default NaN instead of carrying its payload across. The invalid flag is raised for a signalling NaN input and is not sticky: it describes only the conversion that produced the current result.

Top module: `hpw_widen`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `result` and `invalid` change only on such cycles and hold their values otherwise.
- R2: While `rst` is high and after it is released, `out_valid`, `result` and `invalid` are 0 until the first accepted input.
- R3: An input with exponent field (bits 14:10) 0 and fraction field (bits 9:0) 0 gives a zero with the input's sign bit (bit 15) in bit 31.
- R4: An input with exponent field e in 1..30 gives exponent e+112 in result bits 30:23 and the input fraction in result bits 22:13, with result bits 12:0 zero.
- R5: An input with exponent 0 and a nonzero fraction f is normalized. If the highest set bit of f is at position p, the result exponent is 103+p and result bits 22:13 are f shifted left by 10-p, with the leading one dropped.
- R6: With `alt_fmt` low, exponent 31 with fraction 0 gives an infinity of the input's sign (exponent 0xFF, fraction 0), and `invalid` stays low.
- R7: With `alt_fmt` high, exponent 31 is finite and converts as in R4 (result exponent 143). `invalid` is never raised in this mode.
- R8: With `alt_fmt` low, exponent 31 with a nonzero fraction is a NaN. Fraction bit 9 set means quiet and bit 9 clear means signalling. `invalid` is high for a signalling NaN and low for every other input.
- R9: With `alt_fmt` and `dnan_en` low, a NaN gives sign kept, exponent 0xFF, result bit 22 set, result bits 21:13 equal to input bits 8:0, and result bits 12:0 zero.
- R10: With `alt_fmt` low and `dnan_en` high, every NaN gives 0x7FC00000, and `invalid` still follows R8. `dnan_en` has no effect on non-NaN inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `half_in` and the mode inputs in this cycle |
| alt_fmt | input | 1 | 1: half format without infinity/NaN encodings |
| dnan_en | input | 1 | 1: NaN inputs yield the default NaN |
| half_in | input | 16 | Half-precision operand |
| out_valid | output | 1 | `result` and `invalid` refer to the previous cycle's accepted input |
| result | output | 32 | Single-precision result |
| invalid | output | 1 | Invalid-operation flag for the current result |

## Verification
Each accepted operand produces its result and flag one cycle later, at the same edge that raises `out_valid`. The bench therefore drives an operand at a falling edge and checks it at the next falling edge, while the following operand is being driven. Idle cycles are checked one falling edge after `in_valid` drops, to confirm that `out_valid` is low and that `result` and `invalid` still hold the previous values. Expected values come from real-number arithmetic on the half operand in the bench, with NaN and infinity encodings written out from the requirements. The sweep covers all 65536 operands in each format and the NaN, subnormal and top-binade regions with default-NaN on.

// File: rtl/hpw_pkg.sv
package hpw_pkg;

    // Field widths of the two formats
    localparam int H_EXP_W  = 5;
    localparam int H_FRAC_W = 10;
    localparam int S_EXP_W  = 8;
    localparam int S_FRAC_W = 23;

    localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;
    localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;
    localparam int H_BIAS   = (1 << (H_EXP_W - 1)) - 1;
    localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
    localparam int REBIAS   = S_BIAS - H_BIAS;
    localparam int PAD_W    = S_FRAC_W - H_FRAC_W;
    localparam int POS_W    = $clog2(H_FRAC_W);
    localparam int SH_W     = $clog2(H_FRAC_W + 1);

    typedef enum logic [2:0] {
        K_ZERO,
        K_SUB,
        K_NORM,
        K_INF,
        K_QNAN,
        K_SNAN
    } kind_e;

    typedef struct packed {
        logic                sign;
        logic [H_EXP_W-1:0]  exp;
        logic [H_FRAC_W-1:0] frac;
        kind_e               kind;
    } half_parts_t;

    typedef struct packed {
        logic                sign;
        logic [S_EXP_W-1:0]  exp;
        logic [S_FRAC_W-1:0] frac;
    } sgl_t;

    // Position of the most significant set bit of a nonzero fraction
    function automatic logic [POS_W-1:0] top_one_pos(input logic [H_FRAC_W-1:0] f);
        logic [POS_W-1:0] pos;
        pos = '0;
        for (int i = 0; i < H_FRAC_W; i++) begin
            if (f[i]) pos = POS_W'(i);
        end
        return pos;
    endfunction

    // Positive, all-ones exponent, only the quiet bit set
    function automatic sgl_t default_nan();
        sgl_t d;
        d.sign = 1'b0;
        d.exp  = '1;
        d.frac = '0;
        d.frac[S_FRAC_W-1] = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/hpw_classify.sv
module hpw_classify
    import hpw_pkg::*;
(
    input  logic [H_W-1:0] half_in,
    input  logic           alt_fmt,
    output half_parts_t    parts
);
    logic                sgn;
    logic [H_EXP_W-1:0]  ex;
    logic [H_FRAC_W-1:0] fr;
    logic                ex_ones;
    logic                ex_zero;
    logic                fr_zero;

    assign sgn     = half_in[H_W-1];
    assign ex      = half_in[H_W-2 -: H_EXP_W];
    assign fr      = half_in[H_FRAC_W-1:0];
    assign ex_ones = &ex;
    assign ex_zero = ~|ex;
    assign fr_zero = ~|fr;

    always_comb begin
        parts.sign = sgn;
        parts.exp  = ex;
        parts.frac = fr;
        if (ex_ones && !alt_fmt) begin
            if (fr_zero)
                parts.kind = K_INF;
            else if (fr[H_FRAC_W-1])
                parts.kind = K_QNAN;
            else
                parts.kind = K_SNAN;
        end else if (ex_zero) begin
            parts.kind = fr_zero ? K_ZERO : K_SUB;
        end else begin
            parts.kind = K_NORM;
        end
    end
endmodule

// File: rtl/hpw_normalize.sv
module hpw_normalize
    import hpw_pkg::*;
(
    input  logic [H_FRAC_W-1:0] frac,
    output logic [S_EXP_W-1:0]  norm_exp,
    output logic [H_FRAC_W-1:0] norm_frac
);
    logic [POS_W-1:0] lead;
    logic [SH_W-1:0]  shift;

    assign lead      = top_one_pos(frac);
    assign shift     = SH_W'(H_FRAC_W) - SH_W'(lead);
    // Leading one is shifted out past the top of the field
    assign norm_frac = frac << shift;
    assign norm_exp  = S_EXP_W'(REBIAS + 1) - S_EXP_W'(shift);
endmodule

// File: rtl/hpw_assemble.sv
module hpw_assemble
    import hpw_pkg::*;
(
    input  half_parts_t         parts,
    input  logic [S_EXP_W-1:0]  sub_exp,
    input  logic [H_FRAC_W-1:0] sub_frac,
    input  logic                dnan_en,
    output sgl_t                out,
    output logic                inv
);
    logic [S_EXP_W-1:0] norm_exp;

    assign norm_exp = S_EXP_W'(parts.exp) + S_EXP_W'(REBIAS);

    always_comb begin
        out.sign = parts.sign;
        out.exp  = '0;
        out.frac = '0;
        inv      = 1'b0;
        unique case (parts.kind)
            K_ZERO: begin
                out.exp  = '0;
                out.frac = '0;
            end
            K_SUB: begin
                out.exp  = sub_exp;
                out.frac = {sub_frac, {PAD_W{1'b0}}};
            end
            K_NORM: begin
                out.exp  = norm_exp;
                out.frac = {parts.frac, {PAD_W{1'b0}}};
            end
            K_INF: begin
                out.exp  = '1;
                out.frac = '0;
            end
            K_QNAN, K_SNAN: begin
                inv = (parts.kind == K_SNAN);
                if (dnan_en) begin
                    out = default_nan();
                end else begin
                    out.exp  = '1;
                    out.frac = {1'b1, parts.frac[H_FRAC_W-2:0], {PAD_W{1'b0}}};
                end
            end
            default: begin
                out.exp  = '0;
                out.frac = '0;
            end
        endcase
    end
endmodule

// File: rtl/hpw_widen.sv
module hpw_widen
    import hpw_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           alt_fmt,
    input  logic           dnan_en,
    input  logic [H_W-1:0] half_in,
    output logic           out_valid,
    output logic [S_W-1:0] result,
    output logic           invalid
);
    half_parts_t         parts;
    logic [S_EXP_W-1:0]  sub_exp;
    logic [H_FRAC_W-1:0] sub_frac;
    sgl_t                conv;
    logic                conv_inv;

    hpw_classify u_classify (
        .half_in (half_in),
        .alt_fmt (alt_fmt),
        .parts   (parts)
    );

    hpw_normalize u_normalize (
        .frac      (parts.frac),
        .norm_exp  (sub_exp),
        .norm_frac (sub_frac)
    );

    hpw_assemble u_assemble (
        .parts    (parts),
        .sub_exp  (sub_exp),
        .sub_frac (sub_frac),
        .dnan_en  (dnan_en),
        .out      (conv),
        .inv      (conv_inv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= conv;
                invalid <= conv_inv;
            end
        end
    end
endmodule

// File: rtl/hpw_widen_checker.sv
module hpw_widen_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        alt_fmt,
    input logic        dnan_en,
    input logic [15:0] half_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        invalid
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(invalid)));

    a_r3_signed_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && half_in[14:0] == 15'd0) |=> (result == {$past(half_in[15]), 31'd0}));

    a_r7_alt_no_invalid: assert property (@(posedge clk) disable iff (rst)
        (in_valid && alt_fmt) |=> !invalid);

    a_r8_invalid_means_nan: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (result[30:22] == 9'h1FF));

    a_r10_default_nan: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dnan_en && !alt_fmt && half_in[14:10] == 5'h1F && half_in[9:0] != 10'd0)
        |=> (result == 32'h7FC0_0000));
endmodule

bind hpw_widen hpw_widen_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .alt_fmt   (alt_fmt),
    .dnan_en   (dnan_en),
    .half_in   (half_in),
    .out_valid (out_valid),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/hpw_widen_test.sv
module hpw_widen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        alt_fmt = 1'b0;
    logic        dnan_en = 1'b0;
    logic [15:0] half_in = 16'd0;
    logic        out_valid;
    logic [31:0] result;
    logic        invalid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        pend = 1'b0;
    logic [31:0] exp_res;
    logic        exp_inv;
    string       exp_req;
    logic [15:0] exp_in;

    always #10 clk = ~clk;

    hpw_widen uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .alt_fmt(alt_fmt),
        .dnan_en(dnan_en), .half_in(half_in), .out_valid(out_valid),
        .result(result), .invalid(invalid)
    );

    function automatic logic [32:0] model(input logic [15:0] h, input logic alt, input logic dn);
        logic        s;
        int          e;
        int          f;
        real         mag;
        logic [63:0] b;
        logic [31:0] r;
        logic        iv;
        s  = h[15];
        e  = int'(h[14:10]);
        f  = int'(h[9:0]);
        iv = 1'b0;
        if (!alt && e == 31) begin
            if (f == 0) r = {s, 8'hFF, 23'd0};
            else begin
                iv = !h[9];
                r  = dn ? 32'h7FC0_0000 : {s, 8'hFF, 1'b1, h[8:0], 13'd0};
            end
        end else if (e == 0 && f == 0) begin
            r = {s, 31'd0};
        end else begin
            if (e == 0) mag = real'(f) * (2.0 ** (-24));
            else        mag = real'(1024 + f) * (2.0 ** (e - 25));
            b = $realtobits(mag);
            r = {s, 8'(b[62:52] - 11'd896), b[51:29]};
        end
        return {iv, r};
    endfunction

    function automatic string req_of(input logic [15:0] h, input logic alt, input logic dn);
        if (h[14:10] == 5'h1F && alt) return "R7";
        if (h[14:10] == 5'h1F && h[9:0] == 0) return "R6";
        if (h[14:10] == 5'h1F) return dn ? "R10/R8" : "R9/R8";
        if (h[14:10] == 0 && h[9:0] == 0) return "R3";
        if (h[14:10] == 0) return "R5";
        return dn ? "R4/R10" : "R4";
    endfunction

    task automatic check_pending();
        checks++;
        if (!out_valid || result !== exp_res || invalid !== exp_inv) begin
            fails++;
            $display("FAIL %s in=%h: got v=%b res=%h inv=%b, expected v=1 res=%h inv=%b",
                     exp_req, exp_in, out_valid, result, invalid, exp_res, exp_inv);
        end
    endtask

    task automatic apply(input logic [15:0] h, input logic alt, input logic dn);
        logic [32:0] m;
        @(negedge clk);
        if (pend) check_pending();
        in_valid = 1'b1;
        half_in  = h;
        alt_fmt  = alt;
        dnan_en  = dn;
        m        = model(h, alt, dn);
        exp_res  = m[31:0];
        exp_inv  = m[32];
        exp_req  = req_of(h, alt, dn);
        exp_in   = h;
        pend     = 1'b1;
    endtask

    // R1: drop the strobe, change the operand, and confirm nothing moves
    task automatic idle_check();
        @(negedge clk);
        if (pend) check_pending();
        pend     = 1'b0;
        in_valid = 1'b0;
        half_in  = ~half_in;
        dnan_en  = ~dnan_en;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== exp_res || invalid !== exp_inv) begin
            fails++;
            $display("FAIL R1 idle: got v=%b res=%h inv=%b, expected v=0 res=%h inv=%b",
                     out_valid, result, invalid, exp_res, exp_inv);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 32'd0 || invalid !== 1'b0) begin
            fails++;
            $display("FAIL R2 reset: got v=%b res=%h inv=%b, expected v=0 res=00000000 inv=0",
                     out_valid, result, invalid);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 32'd0 || invalid !== 1'b0) begin
            fails++;
            $display("FAIL R2 after release: got v=%b res=%h inv=%b, expected v=0 res=00000000 inv=0",
                     out_valid, result, invalid);
        end

        // Standard format, every operand
        for (int v = 0; v < 65536; v++) begin
            apply(16'(v), 1'b0, 1'b0);
            if ((v & 16'h0FFF) == 16'h0FFF) idle_check();
        end
        // Alternative format, every operand (R7)
        for (int v = 0; v < 65536; v++) begin
            apply(16'(v), 1'b1, 1'b0);
            if ((v & 16'h1FFF) == 16'h1FFF) idle_check();
        end
        // Default-NaN on: NaN/inf binade, top finite binade, subnormals (R10)
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 3; k++) begin
                for (int f = 0; f < 1024; f++) begin
                    logic [4:0] ee;
                    ee = (k == 0) ? 5'd0 : (k == 1) ? 5'd30 : 5'd31;
                    apply({1'(s), ee, 10'(f)}, 1'b0, 1'b1);
                end
            end
        end
        // Default-NaN on in the alternative format has no NaN to replace (R7, R10)
        for (int f = 0; f < 1024; f += 37) apply({1'b1, 5'd31, 10'(f)}, 1'b1, 1'b1);
        idle_check();
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout at %0d cycles, expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule